// File: doc/BRIEF.md
# Asynchronous Serial Port with Selectable Serial Clock

This block is a full-duplex asynchronous serial port for 8-bit characters. A transmit data register feeds a shift register that drives `txd`. A receiver oversamples `rxd` sixteen times per bit and delivers each character to a receive data register. Status flags report transmit-data-empty, receive-full, parity error, framing error and overrun. Software-style control comes through level enables (`tx_en`, `rx_en`) and single-cycle strobes: write data, read data, clear errors and write configuration.

The sixteen-per-bit tick that paces both directions comes from one of two sources. The first is an internal programmable divider of the system clock. The second is an external clock on the serial clock pin, which then runs at sixteen times the bit rate. With the internal source selected, the pin can instead drive out a clock at the bit rate. Its rising edge falls in the middle of every transmitted bit, so a receiver can sample on it.

The pin is modelled as separate input, output and output-enable signals. An I/O cell outside the block joins them.

Top module: `ser_port_top`

## Requirements
- R1: With `cfg_ext_clk`=0 the sub-bit tick occurs once every `cfg_div`+1 system clocks. With `cfg_ext_clk`=1, each rising edge of `sck_in` (seen through a two-flop synchronizer) gives one tick. One bit lasts 16 ticks in both cases.
- R2: `sck_oe` is 1 only when the internal source is selected and `cfg_clk_out`=1. `sck_out` is 0 while the transmitter is disabled. Otherwise it is low for the first 8 ticks and high for the last 8 ticks of each bit period, so it rises 8 ticks after each `txd` transition.
- R3: A transmitted frame is a start bit 0, then data bits 0 to 7 with bit 0 first, then the parity bit if enabled, then a stop bit 1. Each bit lasts 16 ticks, and `txd` is 1 when idle.
- R4: With `cfg_par_en`=1 a parity bit follows the data. With `cfg_par_odd`=0 the count of ones over data and parity is even; with `cfg_par_odd`=1 it is odd. The receiver checks the same rule.
- R5: A `tdr_wr` while `tx_en`=1 clears `tx_empty` on the next cycle. The character moves to the shift register at the next bit boundary when the line is idle, or right after the stop bit of the current frame; `tx_empty` returns to 1 at that point. Characters written in time go out back to back.
- R6: While `tx_en`=0, `tx_empty` is 1 and `txd` is 1 from the next cycle on, and a frame in progress is abandoned. A `tdr_wr` while `tx_en`=0 has no effect.
- R7: A start bit is taken only on a low `rxd` after the line has been seen high. It is confirmed low at the 8th tick, or else ignored. Every later bit is sampled at the same mid-bit tick.
- R8: At the stop-bit sample, if `rx_full`=0 (or `rdr_rd` is high in that cycle), the character goes to `rdr_data` and `rx_full` becomes 1. `rdr_rd` clears `rx_full`.
- R9: `frm_err` is set when the sampled stop bit is 0. `par_err` is set when the received parity breaks the rule of R4. Both stay set until `err_clr`.
- R10: When a character completes while `rx_full`=1 and no read is under way, `ovr_err` is set and the character is dropped, so `rdr_data`, `par_err` and `frm_err` are unchanged.
- R11: While `rx_en`=0, `rx_full`, `par_err`, `frm_err`, `ovr_err` and `rdr_data` are unchanged except by `rdr_rd` and `err_clr`, and incoming frames are ignored.
- R12: A `cfg_wr` updates the configuration only when `tx_en`=0 and `rx_en`=0; otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_ext_clk | input | 1 | 1 selects the external 16x clock on the pin |
| cfg_clk_out | input | 1 | 1 drives the bit-rate clock out (internal source only) |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_div | input | DIV_W | Internal divider: tick every cfg_div+1 clocks |
| tdr_wr | input | 1 | Transmit data write strobe |
| tdr_data | input | DATA_W | Transmit character |
| rdr_rd | input | 1 | Receive data read strobe (clears rx_full) |
| err_clr | input | 1 | Clears par_err, frm_err and ovr_err |
| rdr_data | output | DATA_W | Last accepted received character |
| tx_empty | output | 1 | Transmit data register empty |
| rx_full | output | 1 | Receive data register full |
| par_err | output | 1 | Parity error flag |
| frm_err | output | 1 | Framing error flag |
| ovr_err | output | 1 | Overrun error flag |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| sck_in | input | 1 | Serial clock pin, input side |
| sck_out | output | 1 | Serial clock pin, output value |
| sck_oe | output | 1 | Serial clock pin, output enable |

## Verification
The bench compares `txd`, `sck_out`, `sck_oe` and `tx_empty` with a queue-based model on every clock. It also samples whole frames at mid-bit, so a design with the bit order reversed, the parity polarity flipped or a bit too many would show a wrong bit. It measures the distance from a `txd` edge to the next `sck_out` rise, which catches a clock output that rises on the bit edge rather than the bit centre. Further tests cover configuration writes while enabled (a design that took them would change frame length or lose its clock), disabling mid-frame, a short low glitch on `rxd` (a receiver that skipped start confirmation would accept a false character), and a second character arriving while full (a design that overwrote would change `rdr_data`). It also checks that flags hold across a receiver disable.

// File: rtl/ser_pkg.sv
// Shared types and constants for the asynchronous serial port.
// Assumes a fixed oversampling ratio of 16 sub-bit ticks per bit.
package ser_pkg;
    localparam int unsigned OVS  = 16;
    localparam int unsigned PH_W = $clog2(OVS);

    // Latched mode bits; written only while both directions are disabled.
    typedef struct packed {
        logic ext_clk;
        logic clk_out;
        logic par_en;
        logic par_odd;
    } ser_cfg_t;
endpackage

// File: rtl/ser_tick_gen.sv
// Sub-bit tick source. Selects between an internal divider of the system
// clock and rising edges of an external 16x clock. Assumes the external
// clock is slower than half the system clock so each edge is seen once.
module ser_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             ext_sel,
    input  logic [DIV_W-1:0] div,
    input  logic             sck_in,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [2:0]       sync;
    logic             wrap;
    logic             ext_edge;

    assign wrap     = (cnt == div);
    assign ext_edge = sync[1] & ~sync[2];
    assign tick     = active & (ext_sel ? ext_edge : wrap);

    // Divider count and external clock synchronizer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            sync <= '0;
        end else begin
            sync <= {sync[1:0], sck_in};
            if (!active || ext_sel || wrap) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ser_tx.sv
// Transmit path: holding register, frame shift register and the sub-bit
// phase counter whose top bit is the bit-rate clock output. Assumes one
// tick is at most one system clock long.
module ser_tx
    import ser_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              tick,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              tx_empty,
    output logic              phase_hi
);
    localparam int FR_W  = DATA_W + 2;
    localparam int REM_W = $clog2(FR_W + 1);

    logic [PH_W-1:0]   ph;
    logic              busy;
    logic [REM_W-1:0]  rem;
    logic [FR_W-1:0]   sh;
    logic [DATA_W-1:0] hold;
    logic              bnd;
    logic              pbit;
    logic [FR_W-1:0]   frame;

    assign bnd      = tick && (ph == '1);
    assign pbit     = (^hold) ^ par_odd;
    assign frame    = {1'b1, (par_en ? pbit : 1'b1), hold};
    assign phase_hi = ph[PH_W-1];

    // Bit phase, frame sequencing and holding-register flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph       <= '0;
            busy     <= 1'b0;
            rem      <= '0;
            sh       <= '1;
            hold     <= '0;
            txd      <= 1'b1;
            tx_empty <= 1'b1;
        end else if (!tx_en) begin
            ph       <= '0;
            busy     <= 1'b0;
            rem      <= '0;
            txd      <= 1'b1;
            tx_empty <= 1'b1;
        end else begin
            if (tick) begin
                ph <= ph + 1'b1;
            end
            if (bnd) begin
                if (busy && rem != '0) begin
                    txd <= sh[0];
                    sh  <= {1'b1, sh[FR_W-1:1]};
                    rem <= rem - 1'b1;
                end else if (!tx_empty) begin
                    txd      <= 1'b0;
                    sh       <= frame;
                    rem      <= par_en ? REM_W'(FR_W) : REM_W'(FR_W - 1);
                    busy     <= 1'b1;
                    tx_empty <= 1'b1;
                end else begin
                    busy <= 1'b0;
                    txd  <= 1'b1;
                end
            end
            if (wr) begin
                hold     <= wr_data;
                tx_empty <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ser_rx.sv
// Receive path: input synchronizer, start detection with mid-bit
// confirmation, bit sampling, parity and stop checks, and receive flags.
// Assumes the sender's bit rate matches the local tick rate.
module ser_rx
    import ser_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              tick,
    input  logic              rxd,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              rd,
    input  logic              clr,
    output logic [DATA_W-1:0] rdr_data,
    output logic              rx_full,
    output logic              par_err,
    output logic              frm_err,
    output logic              ovr_err
);
    localparam int IDX_W = $clog2(DATA_W + 3);
    localparam logic [PH_W-1:0] MID = PH_W'(OVS / 2 - 1);

    logic [1:0]        line_s;
    logic              line;
    logic              busy;
    logic              armed;
    logic [PH_W-1:0]   ph;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  last;
    logic [DATA_W-1:0] shd;
    logic              pbit;
    logic              sample;
    logic              done;
    logic              mism;

    assign line   = line_s[1];
    assign last   = par_en ? IDX_W'(DATA_W + 2) : IDX_W'(DATA_W + 1);
    assign sample = rx_en && tick && busy && (ph == MID);
    assign done   = sample && (idx == last);
    assign mism   = par_en && (((^shd) ^ pbit) != par_odd);

    // Synchronizer, start detection and bit sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_s <= 2'b11;
            busy   <= 1'b0;
            armed  <= 1'b0;
            ph     <= '0;
            idx    <= '0;
            shd    <= '0;
            pbit   <= 1'b0;
        end else begin
            line_s <= {line_s[0], rxd};
            if (!rx_en) begin
                busy  <= 1'b0;
                armed <= 1'b0;
                ph    <= '0;
            end else if (tick) begin
                if (!busy) begin
                    if (line) begin
                        armed <= 1'b1;
                    end else if (armed) begin
                        busy <= 1'b1;
                        ph   <= PH_W'(1);
                        idx  <= '0;
                    end
                end else begin
                    ph <= ph + 1'b1;
                    if (ph == MID) begin
                        if (idx == '0) begin
                            if (line) begin
                                busy <= 1'b0;
                            end else begin
                                idx <= idx + 1'b1;
                            end
                        end else if (idx <= IDX_W'(DATA_W)) begin
                            shd <= {line, shd[DATA_W-1:1]};
                            idx <= idx + 1'b1;
                        end else if (idx != last) begin
                            pbit <= line;
                            idx  <= idx + 1'b1;
                        end else begin
                            busy  <= 1'b0;
                            armed <= 1'b0;
                        end
                    end
                end
            end
        end
    end

    // Receive data register and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdr_data <= '0;
            rx_full  <= 1'b0;
            par_err  <= 1'b0;
            frm_err  <= 1'b0;
            ovr_err  <= 1'b0;
        end else begin
            if (done) begin
                if (rx_full && !rd) begin
                    ovr_err <= 1'b1;
                end else begin
                    rdr_data <= shd;
                    rx_full  <= 1'b1;
                    frm_err  <= frm_err | ~line;
                    par_err  <= par_err | mism;
                end
            end else if (rd) begin
                rx_full <= 1'b0;
            end
            if (clr) begin
                par_err <= 1'b0;
                frm_err <= 1'b0;
                ovr_err <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ser_port_top.sv
// Asynchronous serial port top: configuration latch, tick source,
// transmitter and receiver. Assumes the serial clock pin is joined from
// sck_in / sck_out / sck_oe by an I/O cell outside this block.
module ser_port_top
    import ser_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              cfg_wr,
    input  logic              cfg_ext_clk,
    input  logic              cfg_clk_out,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              tdr_wr,
    input  logic [DATA_W-1:0] tdr_data,
    input  logic              rdr_rd,
    input  logic              err_clr,
    output logic [DATA_W-1:0] rdr_data,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              par_err,
    output logic              frm_err,
    output logic              ovr_err,
    output logic              txd,
    input  logic              rxd,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe
);
    ser_cfg_t         cfg;
    logic [DIV_W-1:0] div_q;
    logic             tick;
    logic             phase_hi;

    // Configuration latch, open only while both directions are off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg   <= '0;
            div_q <= '0;
        end else if (cfg_wr && !tx_en && !rx_en) begin
            cfg   <= '{ext_clk: cfg_ext_clk, clk_out: cfg_clk_out,
                       par_en: cfg_par_en, par_odd: cfg_par_odd};
            div_q <= cfg_div;
        end
    end

    assign sck_oe  = ~cfg.ext_clk & cfg.clk_out;
    assign sck_out = phase_hi;

    ser_tick_gen #(.DIV_W(DIV_W)) tick_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (tx_en | rx_en),
        .ext_sel (cfg.ext_clk),
        .div     (div_q),
        .sck_in  (sck_in),
        .tick    (tick)
    );

    ser_tx #(.DATA_W(DATA_W)) tx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .tick     (tick),
        .par_en   (cfg.par_en),
        .par_odd  (cfg.par_odd),
        .wr       (tdr_wr),
        .wr_data  (tdr_data),
        .txd      (txd),
        .tx_empty (tx_empty),
        .phase_hi (phase_hi)
    );

    ser_rx #(.DATA_W(DATA_W)) rx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_en    (rx_en),
        .tick     (tick),
        .rxd      (rxd),
        .par_en   (cfg.par_en),
        .par_odd  (cfg.par_odd),
        .rd       (rdr_rd),
        .clr      (err_clr),
        .rdr_data (rdr_data),
        .rx_full  (rx_full),
        .par_err  (par_err),
        .frm_err  (frm_err),
        .ovr_err  (ovr_err)
    );
endmodule

// File: rtl/ser_port_chk.sv
// Property checker for the serial port, bound to the top module.
// Observes ports only.
module ser_port_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_en,
    input logic              rx_en,
    input logic              tdr_wr,
    input logic              rdr_rd,
    input logic              err_clr,
    input logic              tx_empty,
    input logic              txd,
    input logic              sck_out,
    input logic              sck_oe,
    input logic              rx_full,
    input logic              par_err,
    input logic              frm_err,
    input logic              ovr_err,
    input logic [DATA_W-1:0] rdr_data
);
    // R6: a disabled transmitter reports empty and idles the line.
    p_empty_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> tx_empty);
    p_line_idle_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> txd);

    // R2: no clock output activity with the transmitter off.
    p_sck_low_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !sck_out);

    // R5: an accepted write leaves the holding register occupied.
    p_write_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && tdr_wr) |=> !tx_empty);

    // R12: configuration cannot move while either direction is on.
    p_cfg_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en || rx_en) |=> $stable(sck_oe));

    // R10: an overrun never overwrites the held character.
    p_ovr_keeps_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_err) |-> $stable(rdr_data));

    // R9: error clear wins over any error set in the same cycle.
    p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> (!par_err && !frm_err && !ovr_err));

    // R11: receive state holds while the receiver is off.
    p_rx_hold_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !rdr_rd && !err_clr) |=>
            ($stable(rx_full) && $stable(par_err) && $stable(frm_err)
             && $stable(ovr_err) && $stable(rdr_data)));
endmodule

bind ser_port_top ser_port_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (tx_en),
    .rx_en    (rx_en),
    .tdr_wr   (tdr_wr),
    .rdr_rd   (rdr_rd),
    .err_clr  (err_clr),
    .tx_empty (tx_empty),
    .txd      (txd),
    .sck_out  (sck_out),
    .sck_oe   (sck_oe),
    .rx_full  (rx_full),
    .par_err  (par_err),
    .frm_err  (frm_err),
    .ovr_err  (ovr_err),
    .rdr_data (rdr_data)
);

// File: tb/ser_port_top_tb_top.sv
// Bench for the serial port: a queue-based transmit model compared on
// every clock plus directed receive and corner-case checks.
module ser_port_top_tb_top;
    localparam int DIV_W  = 8;
    localparam int DATA_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0, rx_en = 1'b0, cfg_wr = 1'b0;
    logic cfg_ext_clk = 1'b0, cfg_clk_out = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic tdr_wr = 1'b0, rdr_rd = 1'b0, err_clr = 1'b0;
    logic [DATA_W-1:0] tdr_data = '0;
    logic [DATA_W-1:0] rdr_data;
    logic tx_empty, rx_full, par_err, frm_err, ovr_err, txd, sck_out, sck_oe;
    logic rxd = 1'b1;
    logic sck_in = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit sck_run = 1'b0;
    int sck_cnt = 0;

    always #4 clk = ~clk;

    ser_port_top #(.DIV_W(DIV_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .cfg_wr(cfg_wr),
        .cfg_ext_clk(cfg_ext_clk), .cfg_clk_out(cfg_clk_out), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_div(cfg_div), .tdr_wr(tdr_wr), .tdr_data(tdr_data),
        .rdr_rd(rdr_rd), .err_clr(err_clr), .rdr_data(rdr_data), .tx_empty(tx_empty),
        .rx_full(rx_full), .par_err(par_err), .frm_err(frm_err), .ovr_err(ovr_err),
        .txd(txd), .rxd(rxd), .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe)
    );

    // External 16x clock source: period of 6 system clocks.
    always @(negedge clk) begin
        if (sck_run) begin
            sck_cnt = (sck_cnt == 5) ? 0 : sck_cnt + 1;
            sck_in  = (sck_cnt < 3);
        end else begin
            sck_cnt = 0;
            sck_in  = 1'b0;
        end
    end

    // Transmit reference model (behavioural, bit queue).
    bit m_ext, m_clko, m_pe, m_po;
    int m_div, m_cnt, m_tph;
    bit [2:0] m_hist;
    bit m_txd, m_empty;
    bit [7:0] m_tdr;
    bit m_q[$];
    always @(posedge clk) begin
        bit act, tk, bnd;
        if (!rst_n) begin
            m_ext = 0; m_clko = 0; m_pe = 0; m_po = 0; m_div = 0; m_cnt = 0;
            m_hist = 0; m_tph = 0; m_txd = 1; m_empty = 1; m_tdr = 0; m_q.delete();
        end else begin
            act = tx_en || rx_en;
            tk  = act && (m_ext ? (m_hist[1] && !m_hist[2]) : (m_cnt == m_div));
            if (!act || m_ext || m_cnt == m_div) m_cnt = 0; else m_cnt++;
            m_hist = {m_hist[1:0], sck_in};
            if (!tx_en) begin
                m_tph = 0; m_txd = 1; m_empty = 1; m_q.delete();
            end else begin
                bnd = tk && (m_tph == 15);
                if (tk) m_tph = (m_tph + 1) % 16;
                if (bnd) begin
                    if (m_q.size() > 0) begin
                        m_txd = m_q.pop_front();
                    end else if (!m_empty) begin
                        m_txd = 0;
                        for (int i = 0; i < 8; i++) m_q.push_back(m_tdr[i]);
                        if (m_pe) m_q.push_back((^m_tdr) ^ m_po);
                        m_q.push_back(1'b1);
                        m_empty = 1;
                    end else begin
                        m_txd = 1;
                    end
                end
                if (tdr_wr) begin m_tdr = tdr_data; m_empty = 0; end
            end
            if (cfg_wr && !tx_en && !rx_en) begin
                m_ext = cfg_ext_clk; m_clko = cfg_clk_out; m_pe = cfg_par_en;
                m_po = cfg_par_odd; m_div = int'(cfg_div);
            end
        end
    end

    // Per-clock comparison of transmit-side outputs (R3 R2 R5 R6).
    always @(negedge clk) begin
        if (rst_n) begin
            logic [3:0] a, e;
            a = {txd, sck_out, sck_oe, tx_empty};
            e = {m_txd, (m_tph >= 8), (!m_ext && m_clko), m_empty};
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL R3 R2 R5 model at cycle %0d actual=%b expected=%b", cyc, a, e);
            end
        end
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual=%0d expected<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input bit ext, input bit clko, input bit pe, input bit po, input int dv);
        cfg_ext_clk = ext; cfg_clk_out = clko; cfg_par_en = pe; cfg_par_odd = po;
        cfg_div = DIV_W'(dv); cfg_wr = 1'b1;
        clks(1);
        cfg_wr = 1'b0;
    endtask

    task automatic write_tx(input logic [7:0] d);
        tdr_data = d; tdr_wr = 1'b1;
        clks(1);
        tdr_wr = 1'b0;
    endtask

    // Sample a transmitted frame at mid-bit; bit 0 is the start bit.
    task automatic grab_frame(input int bp, input int nbits, output logic [10:0] bits);
        bits = '1;
        while (txd !== 1'b0) clks(1);
        clks(bp / 2);
        bits[0] = txd;
        for (int i = 1; i < nbits; i++) begin
            clks(bp);
            bits[i] = txd;
        end
    endtask

    task automatic rx_frame(input logic [7:0] d, input bit use_par, input bit pb,
                            input bit stopv, input int bp);
        rxd = 1'b0; clks(bp);
        for (int i = 0; i < 8; i++) begin rxd = d[i]; clks(bp); end
        if (use_par) begin rxd = pb; clks(bp); end
        rxd = stopv; clks(bp);
        rxd = 1'b1; clks(bp);
    endtask

    initial begin
        logic [10:0] fr;
        int k;
        clks(5);
        rst_n = 1'b1;
        clks(1);
        // Reset state.
        chk("R3 reset txd idle", txd, 1);
        chk("R6 reset tx_empty", tx_empty, 1);
        chk("R8 reset rx_full", rx_full, 0);
        chk("R9 reset errors", {par_err, frm_err, ovr_err}, 0);
        chk("R2 reset sck_oe", sck_oe, 0);

        // Internal clock, divide by 4, clock output on, no parity.
        set_cfg(0, 1, 0, 0, 3);
        chk("R2 sck_oe internal", sck_oe, 1);
        tx_en = 1'b1;
        clks(2);
        write_tx(8'hA5);
        chk("R5 empty cleared by write", tx_empty, 0);
        grab_frame(64, 10, fr);
        chk("R3 frame A5", fr[9:0], {1'b1, 8'hA5, 1'b0});
        chk("R5 empty after load", tx_empty, 1);
        // Back-to-back character, and clock rise distance (R2).
        write_tx(8'h0F);
        while (txd !== 1'b0) clks(1);
        k = 0;
        while (sck_out !== 1'b1) begin clks(1); k++; end
        chk("R2 sck rises mid-bit (clocks after edge)", k, 32);
        chk("R1 internal tick rate", k, 8 * 4);
        clks(11 * 64);

        // Configuration write while enabled must be ignored (R12).
        set_cfg(1, 1, 1, 0, 3);
        chk("R12 sck_oe unchanged", sck_oe, 1);
        write_tx(8'h81);
        grab_frame(64, 10, fr);
        chk("R12 frame keeps old format", fr[9:0], {1'b1, 8'h81, 1'b0});
        clks(2 * 64);

        // Disable mid-frame (R6).
        write_tx(8'h3C);
        while (txd !== 1'b0) clks(1);
        clks(100);
        tx_en = 1'b0;
        clks(1);
        chk("R6 empty forced on disable", tx_empty, 1);
        chk("R6 txd idle on disable", txd, 1);
        write_tx(8'h55);
        chk("R6 write ignored while disabled", tx_empty, 1);
        clks(200);
        chk("R6 no frame after disabled write", txd, 1);

        // Even parity, then odd parity (R4).
        set_cfg(0, 1, 1, 0, 3);
        tx_en = 1'b1; clks(2);
        write_tx(8'h07);
        grab_frame(64, 11, fr);
        chk("R4 even parity frame", fr, {1'b1, 1'b1, 8'h07, 1'b0});
        clks(64);
        tx_en = 1'b0; clks(2);
        set_cfg(0, 1, 1, 1, 3);
        tx_en = 1'b1; clks(2);
        write_tx(8'h07);
        grab_frame(64, 11, fr);
        chk("R4 odd parity frame", fr, {1'b1, 1'b0, 8'h07, 1'b0});
        clks(64);
        tx_en = 1'b0; clks(2);

        // External 16x clock (R1, R2).
        set_cfg(1, 1, 0, 0, 3);
        chk("R2 no clock output with external source", sck_oe, 0);
        sck_run = 1'b1;
        tx_en = 1'b1; clks(4);
        write_tx(8'h5A);
        grab_frame(96, 10, fr);
        chk("R1 external clock frame", fr[9:0], {1'b1, 8'h5A, 1'b0});
        clks(2 * 96);
        tx_en = 1'b0; clks(2);
        sck_run = 1'b0; clks(4);

        // Receive, internal divider, no parity (R7, R8).
        set_cfg(0, 0, 0, 0, 3);
        rx_en = 1'b1; clks(20);
        rx_frame(8'hA5, 0, 0, 1, 64);
        chk("R8 rdr_data", rdr_data, 8'hA5);
        chk("R8 rx_full set", rx_full, 1);
        chk("R9 no errors", {par_err, frm_err, ovr_err}, 0);
        rdr_rd = 1'b1; clks(1); rdr_rd = 1'b0;
        chk("R8 read clears full", rx_full, 0);
        // Short glitch is not a start bit.
        rxd = 1'b0; clks(10); rxd = 1'b1; clks(800);
        chk("R7 glitch rejected", rx_full, 0);
        chk("R7 glitch leaves data", rdr_data, 8'hA5);

        // Odd parity receive (R4, R9).
        rx_en = 1'b0; clks(2);
        set_cfg(0, 0, 1, 1, 3);
        rx_en = 1'b1; clks(20);
        rx_frame(8'h03, 1, 1, 1, 64);
        chk("R4 good odd parity accepted", {rx_full, par_err}, 2'b10);
        chk("R4 data with parity", rdr_data, 8'h03);
        rdr_rd = 1'b1; clks(1); rdr_rd = 1'b0;
        rx_frame(8'h03, 1, 0, 1, 64);
        chk("R9 parity error set", par_err, 1);
        rdr_rd = 1'b1; clks(1); rdr_rd = 1'b0;
        rx_frame(8'h55, 1, 1, 0, 64);
        chk("R9 framing error set", frm_err, 1);
        chk("R9 parity error sticky", par_err, 1);
        chk("R9 data on framing error", rdr_data, 8'h55);
        rdr_rd = 1'b1; err_clr = 1'b1; clks(1); rdr_rd = 1'b0; err_clr = 1'b0;
        chk("R9 errors cleared", {par_err, frm_err, ovr_err}, 0);
        clks(100);

        // Overrun (R10).
        rx_frame(8'h11, 1, 1, 1, 64);
        rx_frame(8'h22, 1, 1, 1, 64);
        chk("R10 overrun flagged", ovr_err, 1);
        chk("R10 first character kept", rdr_data, 8'h11);
        chk("R10 still full", rx_full, 1);

        // Receiver disable keeps everything (R11).
        rx_en = 1'b0; clks(10);
        rx_frame(8'h99, 1, 1, 1, 64);
        chk("R11 flags held", {rx_full, par_err, frm_err, ovr_err}, 4'b1001);
        chk("R11 data held", rdr_data, 8'h11);

        clks(10);
        summary();
        $finish;
    end
endmodule